// File: doc/BRIEF.md
# Cache miss status entry controller

This block is a single miss-tracking entry for a coherent cache. When a miss is allocated, the entry records the order number and ready time of the request and keeps every request that waits on the same line in one of two four-deep target queues. The primary queue holds targets that the outstanding bus request will satisfy. The deferred queue holds targets that need a second request after the response returns. Each target carries a command code, a source tag, an order number and a ready time.

The entry tracks its own ownership state: valid, in-service, pending-dirty, forward, and the two post-response actions (invalidate after and downgrade after). These flags decide where a new target is placed, how a snoop from the bus is answered, and whether a fill can merge the deferred work into the primary queue. The surrounding cache drives one operation per clock on `op_i`. The snoop answer appears combinationally in the same cycle. All state updates take effect at the next rising edge.

Top module: `mse_entry`

## Requirements
- R1: Op codes are none=0, allocate=1, add=2, mark-in-service=3, snoop=4, fill=5, pop=6, promote=7, deallocate=8. Allocate (op 1) on an invalid entry sets valid, clears in-service and all post and dirty flags, and stores order/ready. It also places one target in the primary queue, with source code 2 (prefetcher) when the command is prefetch (code 1) and source code 0 (CPU) otherwise. Allocate on a valid entry sets the sticky error flag and changes nothing else.
- R2: Command codes are read=0, prefetch=1, read-exclusive=2, upgrade=3, store-conditional=4, store-conditional-upgrade=5, store-conditional-fail=6, store-conditional-upgrade-fail=7; codes 2 to 7 need exclusive access. Add (op 2) on an in-service entry goes to the deferred queue if that queue is non-empty, or post-invalidate is set, or the command needs exclusive access and pending-dirty is clear, post-downgrade is set or the entry is a forward. Otherwise it goes to the primary queue.
- R3: A target deferred while post-invalidate is set is stored rewritten: upgrade becomes read-exclusive, store-conditional-upgrade becomes store-conditional-upgrade-fail, store-conditional becomes store-conditional-fail.
- R4: Each queue keeps a needs-exclusive flag and a has-upgrade flag. Only targets whose source is not snoop (source code 1) set them. Upgrade, store-conditional-upgrade and store-conditional set has-upgrade. Rewriting a whole queue clears has-upgrade.
- R5: Mark-in-service (op 3) sets in-service and clears both post flags. It sets pending-dirty when the primary queue needs exclusive access, or when the response inhibit input is high and the shared input is low.
- R6: A snoop (op 4) while the entry is not in service, or while the express input and the downstream-pending input are both high, is reported not handled and changes no flag. If the snoop command needs exclusive access, both queues are rewritten as in R3.
- R7: An in-service snoop with post-invalidate already set is reported handled. Only the deferred queue is rewritten (if the snoop is exclusive); the primary queue is unchanged.
- R8: Otherwise, when pending-dirty is set or the snoop-invalidate input is high, the snoop is appended to the primary queue with source code 1. Pending-dirty also raises the inhibit and supply-exclusive snoop outputs, and an exclusive snoop sets post-invalidate.
- R9: A non-exclusive snoop on the in-service path with post-invalidate clear sets post-downgrade, raises the shared snoop output and is reported handled.
- R10: Promote (op 7) with an empty primary and a non-empty deferred queue swaps the queues, clears the flags of the new deferred queue, takes the entry order from the new head, and sets the entry ready time to the larger of `now_i` and the head's ready time. Promote with a non-empty primary queue sets the error flag.
- R11: Fill (op 5) with shared low, both post flags clear and a deferred queue that needs exclusive access appends all deferred targets behind the primary ones in order. It sets primary needs-exclusive and empties the deferred queue with its flags cleared. Any other fill changes nothing.
- R12: Pop (op 6) removes the primary head; targets leave each queue in arrival order.
- R13: An add or snoop append to a full queue (4 targets) sets the error flag and drops the target.
- R14: Deallocate (op 8) with both queues empty clears valid and in-service. With either queue non-empty it sets the error flag and leaves the entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| cmd_i | input | 3 | Command of the target or snoop |
| order_i | input | 8 | Order number of the target or snoop |
| ready_i | input | 16 | Ready time of a new target |
| now_i | input | 16 | Current time |
| alloc_fwd_i | input | 1 | Allocate as a forwarding entry |
| rsp_shared_i | input | 1 | Response shared bit (service, fill) |
| rsp_inhibit_i | input | 1 | Response inhibit bit (service) |
| snp_express_i | input | 1 | Snoop is an express snoop |
| snp_inval_i | input | 1 | Snoop invalidates |
| down_pend_i | input | 1 | Request still buffered downstream |
| snp_handled_o | output | 1 | Snoop taken by this entry |
| snp_inhibit_o | output | 1 | Assert inhibit on the snoop |
| snp_supply_excl_o | output | 1 | Entry will supply an exclusive copy |
| snp_shared_o | output | 1 | Assert shared on the snooper's response |
| valid_o | output | 1 | Entry allocated |
| in_service_o | output | 1 | Request issued |
| pend_dirty_o | output | 1 | Ownership pending |
| post_inv_o | output | 1 | Invalidate after response |
| post_down_o | output | 1 | Downgrade after response |
| fwd_o | output | 1 | Forwarding entry |
| err_o | output | 1 | Sticky misuse flag |
| pri_count_o | output | 3 | Primary queue occupancy |
| def_count_o | output | 3 | Deferred queue occupancy |
| pri_excl_o | output | 1 | Primary needs exclusive |
| pri_upg_o | output | 1 | Primary has upgrade |
| def_excl_o | output | 1 | Deferred needs exclusive |
| def_upg_o | output | 1 | Deferred has upgrade |
| head_cmd_o | output | 3 | Primary head command |
| head_src_o | output | 2 | Primary head source |
| head_order_o | output | 8 | Primary head order |
| entry_order_o | output | 8 | Entry order number |
| entry_ready_o | output | 16 | Entry ready time |

## Verification
The assertions assume the cache presents at most one operation per cycle and holds the snoop side inputs stable while the snoop is on `op_i`. They also assume an unused op code never appears. The error checks rely on the sticky flag staying high until reset, so every scenario that provokes misuse begins from a fresh reset. The stimulus drives all inputs on the falling edge, returns `op_i` to none after each operation, and reaches full queues and early promote or deallocate only inside those dedicated error scenarios.

// File: rtl/mse_pkg.sv
package mse_pkg;
    parameter int ORDER_W = 8;
    parameter int TIME_W  = 16;

    typedef enum logic [2:0] {
        CMD_READ        = 3'd0,
        CMD_PREFETCH    = 3'd1,
        CMD_READ_EX     = 3'd2,
        CMD_UPGRADE     = 3'd3,
        CMD_SC          = 3'd4,
        CMD_SC_UPG      = 3'd5,
        CMD_SC_FAIL     = 3'd6,
        CMD_SC_UPG_FAIL = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_SNOOP = 2'd1,
        SRC_PF    = 2'd2
    } src_e;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_ALLOC   = 4'd1,
        OP_ADD     = 4'd2,
        OP_SERVICE = 4'd3,
        OP_SNOOP   = 4'd4,
        OP_FILL    = 4'd5,
        OP_POP     = 4'd6,
        OP_PROMOTE = 4'd7,
        OP_DEALLOC = 4'd8
    } op_e;

    typedef struct packed {
        cmd_e               cmd;
        src_e               src;
        logic [ORDER_W-1:0] order;
        logic [TIME_W-1:0]  ready;
    } target_t;

    function automatic logic needs_excl(cmd_e c);
        return c >= CMD_READ_EX;
    endfunction

    function automatic logic is_upgrade(cmd_e c);
        return (c == CMD_UPGRADE) || (c == CMD_SC_UPG) || (c == CMD_SC);
    endfunction

    function automatic cmd_e rewrite_cmd(cmd_e c);
        case (c)
            CMD_UPGRADE: return CMD_READ_EX;
            CMD_SC_UPG:  return CMD_SC_UPG_FAIL;
            CMD_SC:      return CMD_SC_FAIL;
            default:     return c;
        endcase
    endfunction
endpackage

// File: rtl/mse_queue.sv
module mse_queue
    import mse_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop_i,
    input  logic             rewrite_i,
    input  logic             clr_i,
    input  logic             clr_flags_i,
    input  logic             set_excl_i,
    input  logic [CNT_W-1:0] app_n_i,
    input  target_t          app_i [DEPTH],
    output target_t          ent_o [DEPTH],
    output logic [CNT_W-1:0] count_o,
    output logic             excl_o,
    output logic             upg_o
);
    target_t          ent   [DEPTH];
    target_t          ent_n [DEPTH];
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             excl, excl_n, upg, upg_n;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent[i];
        cnt_n  = cnt;
        excl_n = excl;
        upg_n  = upg;
        if (pop_i && cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent[i+1];
            ent_n[DEPTH-1] = '0;
            cnt_n = cnt - 1'b1;
        end
        if (rewrite_i) begin
            for (int i = 0; i < DEPTH; i++) ent_n[i].cmd = rewrite_cmd(ent_n[i].cmd);
            upg_n = 1'b0;
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(app_n_i) && int'(cnt_n) + k < DEPTH) begin
                ent_n[IDX_W'(int'(cnt_n) + k)] = app_i[k];
                if (app_i[k].src != SRC_SNOOP) begin
                    excl_n = excl_n | needs_excl(app_i[k].cmd);
                    upg_n  = upg_n  | is_upgrade(app_i[k].cmd);
                end
            end
        end
        cnt_n = cnt_n + app_n_i;
        if (set_excl_i)  excl_n = 1'b1;
        if (clr_flags_i) begin
            excl_n = 1'b0;
            upg_n  = 1'b0;
        end
        if (clr_i) begin
            cnt_n  = '0;
            excl_n = 1'b0;
            upg_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            cnt  <= '0;
            excl <= 1'b0;
            upg  <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= ent_n[i];
            cnt  <= cnt_n;
            excl <= excl_n;
            upg  <= upg_n;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_o[i] = ent[i];
    end
    assign count_o = cnt;
    assign excl_o  = excl;
    assign upg_o   = upg;

    // R13: occupancy never exceeds the depth
    a_r13_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);

    // R12: a lone pop shrinks the queue by exactly one
    a_r12_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (pop_i && cnt != '0 && app_n_i == '0 && !clr_i) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/mse_snoop.sv
module mse_snoop (
    input  logic in_svc_i,
    input  logic express_i,
    input  logic down_pend_i,
    input  logic excl_i,
    input  logic inval_i,
    input  logic post_inv_i,
    input  logic pend_dirty_i,
    output logic handled_o,
    output logic rw_pri_o,
    output logic rw_def_o,
    output logic append_o,
    output logic inhibit_o,
    output logic supply_o,
    output logic set_pinv_o,
    output logic set_pdown_o,
    output logic shared_o
);
    logic bypass;
    assign bypass = !in_svc_i || (express_i && down_pend_i);

    always_comb begin
        handled_o   = 1'b0;
        rw_pri_o    = 1'b0;
        rw_def_o    = 1'b0;
        append_o    = 1'b0;
        inhibit_o   = 1'b0;
        supply_o    = 1'b0;
        set_pinv_o  = 1'b0;
        set_pdown_o = 1'b0;
        shared_o    = 1'b0;
        if (bypass) begin
            rw_pri_o = excl_i;
            rw_def_o = excl_i;
        end else begin
            handled_o = 1'b1;
            rw_def_o  = excl_i;
            if (!post_inv_i) begin
                if (pend_dirty_i || inval_i) begin
                    append_o   = 1'b1;
                    inhibit_o  = pend_dirty_i;
                    supply_o   = pend_dirty_i;
                    set_pinv_o = excl_i;
                end
                if (!excl_i) begin
                    set_pdown_o = 1'b1;
                    shared_o    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mse_entry.sv
module mse_entry
    import mse_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         op_i,
    input  logic [2:0]         cmd_i,
    input  logic [ORDER_W-1:0] order_i,
    input  logic [TIME_W-1:0]  ready_i,
    input  logic [TIME_W-1:0]  now_i,
    input  logic               alloc_fwd_i,
    input  logic               rsp_shared_i,
    input  logic               rsp_inhibit_i,
    input  logic               snp_express_i,
    input  logic               snp_inval_i,
    input  logic               down_pend_i,
    output logic               snp_handled_o,
    output logic               snp_inhibit_o,
    output logic               snp_supply_excl_o,
    output logic               snp_shared_o,
    output logic               valid_o,
    output logic               in_service_o,
    output logic               pend_dirty_o,
    output logic               post_inv_o,
    output logic               post_down_o,
    output logic               fwd_o,
    output logic               err_o,
    output logic [CNT_W-1:0]   pri_count_o,
    output logic [CNT_W-1:0]   def_count_o,
    output logic               pri_excl_o,
    output logic               pri_upg_o,
    output logic               def_excl_o,
    output logic               def_upg_o,
    output logic [2:0]         head_cmd_o,
    output logic [1:0]         head_src_o,
    output logic [ORDER_W-1:0] head_order_o,
    output logic [ORDER_W-1:0] entry_order_o,
    output logic [TIME_W-1:0]  entry_ready_o
);
    // Entry state
    logic               valid, in_svc, pdirty, pinv, pdown, fwd, err, sel;
    logic [ORDER_W-1:0] ord_q;
    logic [TIME_W-1:0]  rdy_q;
    logic               valid_n, in_svc_n, pdirty_n, pinv_n, pdown_n, fwd_n, err_n, sel_n;
    logic [ORDER_W-1:0] ord_n;
    logic [TIME_W-1:0]  rdy_n;

    // Physical banks; sel names the one acting as primary
    logic             q_pop [2], q_rw [2], q_clr [2], q_clrf [2], q_setx [2];
    logic [CNT_W-1:0] q_appn [2];
    target_t          q_app [2][DEPTH];
    target_t          q_ent [2][DEPTH];
    logic [CNT_W-1:0] q_cnt [2];
    logic             q_excl [2], q_upg [2];

    // Role-level controls
    logic             p_pop, p_rw, p_clrf, p_setx, d_rw, d_clr, d_clrf;
    logic [CNT_W-1:0] p_appn, d_appn;
    target_t          p_app [DEPTH];
    target_t          d_app [DEPTH];
    target_t          pent [DEPTH];
    target_t          dent [DEPTH];
    logic [CNT_W-1:0] pc, dc;

    op_e  op;
    cmd_e cmd;
    assign op  = op_e'(op_i);
    assign cmd = cmd_e'(cmd_i);

    logic is_snoop;
    assign is_snoop = (op == OP_SNOOP) && valid;

    logic s_handled, s_rw_pri, s_rw_def, s_append, s_inhibit, s_supply;
    logic s_set_pinv, s_set_pdown, s_shared;

    mse_snoop u_snoop (
        .in_svc_i    (in_svc),
        .express_i   (snp_express_i),
        .down_pend_i (down_pend_i),
        .excl_i      (needs_excl(cmd)),
        .inval_i     (snp_inval_i),
        .post_inv_i  (pinv),
        .pend_dirty_i(pdirty),
        .handled_o   (s_handled),
        .rw_pri_o    (s_rw_pri),
        .rw_def_o    (s_rw_def),
        .append_o    (s_append),
        .inhibit_o   (s_inhibit),
        .supply_o    (s_supply),
        .set_pinv_o  (s_set_pinv),
        .set_pdown_o (s_set_pdown),
        .shared_o    (s_shared)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pent[i] = q_ent[sel][i];
            dent[i] = q_ent[~sel][i];
        end
        pc = q_cnt[sel];
        dc = q_cnt[~sel];
    end

    logic defer;
    assign defer = in_svc && (dc != '0 || pinv ||
                   (needs_excl(cmd) && (!pdirty || pdown || fwd)));

    always_comb begin
        valid_n = valid;  in_svc_n = in_svc; pdirty_n = pdirty;
        pinv_n  = pinv;   pdown_n  = pdown;  fwd_n    = fwd;
        err_n   = err;    sel_n    = sel;    ord_n    = ord_q;  rdy_n = rdy_q;
        p_pop = 1'b0; p_rw = 1'b0; p_clrf = 1'b0; p_setx = 1'b0;
        d_rw  = 1'b0; d_clr = 1'b0; d_clrf = 1'b0;
        p_appn = '0;  d_appn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            p_app[i] = '0;
            d_app[i] = '0;
        end
        case (op)
            OP_ALLOC: begin
                if (valid) err_n = 1'b1;
                else begin
                    valid_n = 1'b1; in_svc_n = 1'b0; pdirty_n = 1'b0;
                    pinv_n  = 1'b0; pdown_n  = 1'b0; fwd_n = alloc_fwd_i;
                    ord_n   = order_i; rdy_n = ready_i;
                    p_appn  = CNT_W'(1);
                    p_app[0] = '{cmd: cmd, src: (cmd == CMD_PREFETCH) ? SRC_PF : SRC_CPU,
                                 order: order_i, ready: ready_i};
                end
            end
            OP_ADD: begin
                if (!valid) err_n = 1'b1;
                else if (defer) begin
                    if (int'(dc) == DEPTH) err_n = 1'b1;
                    else begin
                        d_appn = CNT_W'(1);
                        d_app[0] = '{cmd: pinv ? rewrite_cmd(cmd) : cmd, src: SRC_CPU,
                                     order: order_i, ready: ready_i};
                    end
                end else begin
                    if (int'(pc) == DEPTH) err_n = 1'b1;
                    else begin
                        p_appn = CNT_W'(1);
                        p_app[0] = '{cmd: cmd, src: SRC_CPU, order: order_i, ready: ready_i};
                    end
                end
            end
            OP_SERVICE: begin
                if (!valid || in_svc) err_n = 1'b1;
                else begin
                    in_svc_n = 1'b1;
                    pdirty_n = q_excl[sel] || (rsp_inhibit_i && !rsp_shared_i);
                    pinv_n   = 1'b0;
                    pdown_n  = 1'b0;
                end
            end
            OP_SNOOP: begin
                if (valid) begin
                    p_rw = s_rw_pri;
                    d_rw = s_rw_def;
                    if (s_append) begin
                        if (int'(pc) == DEPTH) err_n = 1'b1;
                        else begin
                            p_appn = CNT_W'(1);
                            p_app[0] = '{cmd: cmd, src: SRC_SNOOP, order: order_i, ready: now_i};
                        end
                    end
                    if (s_set_pinv)  pinv_n  = 1'b1;
                    if (s_set_pdown) pdown_n = 1'b1;
                end
            end
            OP_FILL: begin
                if (valid && !rsp_shared_i && !pinv && !pdown && q_excl[~sel]) begin
                    if (int'(pc) + int'(dc) > DEPTH) err_n = 1'b1;
                    else begin
                        p_appn = dc;
                        for (int i = 0; i < DEPTH; i++) p_app[i] = dent[i];
                        p_setx = 1'b1;
                        d_clr  = 1'b1;
                    end
                end
            end
            OP_POP: begin
                if (pc == '0) err_n = 1'b1;
                else p_pop = 1'b1;
            end
            OP_PROMOTE: begin
                if (pc != '0) err_n = 1'b1;
                else if (dc != '0) begin
                    sel_n  = ~sel;
                    p_clrf = 1'b1;
                    ord_n  = dent[0].order;
                    rdy_n  = (now_i > dent[0].ready) ? now_i : dent[0].ready;
                end
            end
            OP_DEALLOC: begin
                if (pc != '0 || dc != '0) err_n = 1'b1;
                else begin
                    valid_n = 1'b0; in_svc_n = 1'b0; pdirty_n = 1'b0;
                    pinv_n  = 1'b0; pdown_n  = 1'b0; fwd_n    = 1'b0;
                    p_clrf  = 1'b1; d_clrf   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Map role controls onto the two physical banks
    always_comb begin
        for (int b = 0; b < 2; b++) begin
            logic bp;
            bp = (sel == b[0]);
            q_pop[b]  = bp ? p_pop  : 1'b0;
            q_rw[b]   = bp ? p_rw   : d_rw;
            q_clr[b]  = bp ? 1'b0   : d_clr;
            q_clrf[b] = bp ? p_clrf : d_clrf;
            q_setx[b] = bp ? p_setx : 1'b0;
            q_appn[b] = bp ? p_appn : d_appn;
            for (int i = 0; i < DEPTH; i++) q_app[b][i] = bp ? p_app[i] : d_app[i];
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        mse_queue #(.DEPTH(DEPTH)) u_q (
            .clk        (clk),
            .rst        (rst),
            .pop_i      (q_pop[g]),
            .rewrite_i  (q_rw[g]),
            .clr_i      (q_clr[g]),
            .clr_flags_i(q_clrf[g]),
            .set_excl_i (q_setx[g]),
            .app_n_i    (q_appn[g]),
            .app_i      (q_app[g]),
            .ent_o      (q_ent[g]),
            .count_o    (q_cnt[g]),
            .excl_o     (q_excl[g]),
            .upg_o      (q_upg[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0; in_svc <= 1'b0; pdirty <= 1'b0; pinv <= 1'b0;
            pdown <= 1'b0; fwd    <= 1'b0; err    <= 1'b0; sel  <= 1'b0;
            ord_q <= '0;   rdy_q  <= '0;
        end else begin
            valid <= valid_n; in_svc <= in_svc_n; pdirty <= pdirty_n; pinv <= pinv_n;
            pdown <= pdown_n; fwd    <= fwd_n;    err    <= err_n;    sel  <= sel_n;
            ord_q <= ord_n;   rdy_q  <= rdy_n;
        end
    end

    assign snp_handled_o     = is_snoop && s_handled;
    assign snp_inhibit_o     = is_snoop && s_inhibit;
    assign snp_supply_excl_o = is_snoop && s_supply;
    assign snp_shared_o      = is_snoop && s_shared;
    assign valid_o       = valid;
    assign in_service_o  = in_svc;
    assign pend_dirty_o  = pdirty;
    assign post_inv_o    = pinv;
    assign post_down_o   = pdown;
    assign fwd_o         = fwd;
    assign err_o         = err;
    assign pri_count_o   = pc;
    assign def_count_o   = dc;
    assign pri_excl_o    = q_excl[sel];
    assign pri_upg_o     = q_upg[sel];
    assign def_excl_o    = q_excl[~sel];
    assign def_upg_o     = q_upg[~sel];
    assign head_cmd_o    = pent[0].cmd;
    assign head_src_o    = pent[0].src;
    assign head_order_o  = pent[0].order;
    assign entry_order_o = ord_q;
    assign entry_ready_o = rdy_q;

    // R14: deallocate with queued targets flags an error
    a_r14_dealloc_busy: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DEALLOC && (pri_count_o != '0 || def_count_o != '0)) |=> err_o);

    // R10: promote with a non-empty primary flags an error
    a_r10_promote_busy: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PROMOTE && pri_count_o != '0) |=> err_o);

    // R5: mark-in-service leaves both post flags clear
    a_r5_service_clears: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SERVICE && valid_o && !in_service_o) |=> (in_service_o && !post_inv_o && !post_down_o));

    // R6: a snoop before service is never taken
    a_r6_idle_unhandled: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SNOOP && !in_service_o) |-> !snp_handled_o);

    // R7: once post-invalidate is set, a snoop adds nothing to the primary queue
    a_r7_postinv_still: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SNOOP && in_service_o && post_inv_o && !(snp_express_i && down_pend_i))
        |=> pri_count_o == $past(pri_count_o));
endmodule

// File: tb/tb_mse_entry.sv
module tb_mse_entry;
    import mse_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'd0;
    logic [2:0]  cmd = 3'd0;
    logic [7:0]  ord = 8'd0;
    logic [15:0] rdy = 16'd0, now = 16'd0;
    logic        afwd = 1'b0, shr = 1'b0, inh = 1'b0, expr = 1'b0, inval = 1'b0, dpend = 1'b0;
    logic        handled, s_inh, s_sup, s_shr;
    logic        valid, insvc, pdirty, pinv, pdown, fwd, err;
    logic [2:0]  pcnt, dcnt;
    logic        pex, pup, dex, dup;
    logic [2:0]  hcmd;
    logic [1:0]  hsrc;
    logic [7:0]  hord, eord;
    logic [15:0] erdy;
    logic        c_hand, c_inh, c_sup, c_shr;
    int          n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mse_entry dut (
        .clk(clk), .rst(rst), .op_i(op), .cmd_i(cmd), .order_i(ord), .ready_i(rdy), .now_i(now),
        .alloc_fwd_i(afwd), .rsp_shared_i(shr), .rsp_inhibit_i(inh), .snp_express_i(expr),
        .snp_inval_i(inval), .down_pend_i(dpend),
        .snp_handled_o(handled), .snp_inhibit_o(s_inh), .snp_supply_excl_o(s_sup),
        .snp_shared_o(s_shr), .valid_o(valid), .in_service_o(insvc), .pend_dirty_o(pdirty),
        .post_inv_o(pinv), .post_down_o(pdown), .fwd_o(fwd), .err_o(err),
        .pri_count_o(pcnt), .def_count_o(dcnt), .pri_excl_o(pex), .pri_upg_o(pup),
        .def_excl_o(dex), .def_upg_o(dup), .head_cmd_o(hcmd), .head_src_o(hsrc),
        .head_order_o(hord), .entry_order_o(eord), .entry_ready_o(erdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_op(input op_e o, input cmd_e c = CMD_READ, input int o_n = 0,
                         input int r = 0, input int t = 0);
        @(negedge clk);
        op = o; cmd = c; ord = 8'(o_n); rdy = 16'(r); now = 16'(t);
        #(CLK_PERIOD/4);
        c_hand = handled; c_inh = s_inh; c_sup = s_sup; c_shr = s_shr;
        @(posedge clk);
        #1;
        op = OP_NONE;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; afwd = 0; shr = 0; inh = 0; expr = 0; inval = 0; dpend = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset valid", valid, 0);
        chk("R1 reset err", err, 0);
        chk("R12 reset count", pcnt, 0);
    endtask

    task automatic t_before_service();
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 5, 100);
        chk("R1 valid", valid, 1);
        chk("R1 in_service", insvc, 0);
        chk("R1 head cmd", hcmd, 0);
        chk("R1 head src", hsrc, 0);
        chk("R1 entry order", eord, 5);
        chk("R1 entry ready", erdy, 100);
        chk("R4 read no excl", pex, 0);
        do_op(OP_ADD, CMD_UPGRADE, 6, 110);
        chk("R2 idle to primary", pcnt, 2);
        chk("R2 deferred empty", dcnt, 0);
        chk("R4 upgrade excl", pex, 1);
        chk("R4 upgrade flag", pup, 1);
        do_op(OP_SNOOP, CMD_READ_EX, 9, 0, 120);
        chk("R6 idle snoop unhandled", c_hand, 0);
        chk("R6 upgrade flag cleared", pup, 0);
        chk("R6 no append", pcnt, 2);
        chk("R6 no post flag", pdown | pinv, 0);
        do_op(OP_POP);
        chk("R12 pop order", hord, 6);
        chk("R6 upgrade rewritten", hcmd, 2);
        do_op(OP_POP);
        do_op(OP_DEALLOC);
        chk("R14 dealloc valid", valid, 0);
        chk("R14 dealloc no err", err, 0);
        do_op(OP_ALLOC, CMD_PREFETCH, 1, 0);
        chk("R1 prefetch source", hsrc, 2);
    endtask

    task automatic t_service_route();
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 10, 0);
        shr = 0; inh = 0;
        do_op(OP_SERVICE);
        chk("R5 in service", insvc, 1);
        chk("R5 clean no dirty", pdirty, 0);
        do_op(OP_ADD, CMD_READ, 11, 0);
        chk("R2 shared read primary", pcnt, 2);
        do_op(OP_ADD, CMD_READ_EX, 12, 40);
        chk("R2 excl without dirty deferred", dcnt, 1);
        do_op(OP_ADD, CMD_READ, 13, 0);
        chk("R2 behind deferred", dcnt, 2);
        chk("R2 primary unchanged", pcnt, 2);
        do_op(OP_SNOOP, CMD_READ, 20, 0, 25);
        chk("R9 handled", c_hand, 1);
        chk("R9 shared out", c_shr, 1);
        chk("R9 no inhibit", c_inh, 0);
        chk("R9 post downgrade", pdown, 1);
        chk("R9 no append", pcnt, 2);
        inval = 1;
        do_op(OP_SNOOP, CMD_READ_EX, 21, 0, 30);
        chk("R8 handled", c_hand, 1);
        chk("R8 no inhibit clean", c_inh, 0);
        chk("R8 post invalidate", pinv, 1);
        chk("R8 appended", pcnt, 3);
        chk("R4 snoop no excl", pex, 0);
        inval = 0;
        do_op(OP_ADD, CMD_UPGRADE, 14, 0);
        chk("R2 deferred on post-inv", dcnt, 3);
        chk("R3 upgrade flag not set", dup, 0);
        inval = 1;
        do_op(OP_SNOOP, CMD_READ_EX, 22, 0, 35);
        inval = 0;
        chk("R7 handled", c_hand, 1);
        chk("R7 no append", pcnt, 3);
        do_op(OP_POP);
        do_op(OP_POP);
        chk("R8 snoop source", hsrc, 1);
        chk("R8 snoop order", hord, 21);
        do_op(OP_POP);
        do_op(OP_PROMOTE, CMD_READ, 0, 0, 50);
        chk("R10 swapped primary", pcnt, 3);
        chk("R10 deferred empty", dcnt, 0);
        chk("R10 entry order", eord, 12);
        chk("R10 ready max", erdy, 50);
        chk("R10 new deferred flags", dex, 0);
        do_op(OP_POP);
        do_op(OP_POP);
        chk("R3 rewritten upgrade", hcmd, 2);
        chk("R3 order", hord, 14);
        do_op(OP_POP);
        do_op(OP_DEALLOC);
        chk("R14 valid cleared", valid, 0);
        chk("R14 service cleared", insvc, 0);
    endtask

    task automatic t_dirty();
        do_reset();
        do_op(OP_ALLOC, CMD_READ_EX, 1, 0);
        do_op(OP_SERVICE);
        chk("R5 dirty from queue", pdirty, 1);
        do_op(OP_SNOOP, CMD_READ, 2, 0, 5);
        chk("R8 inhibit", c_inh, 1);
        chk("R8 supply", c_sup, 1);
        chk("R9 shared", c_shr, 1);
        chk("R8 dirty append", pcnt, 2);
        chk("R9 no post inv", pinv, 0);
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        inh = 1; shr = 0;
        do_op(OP_SERVICE);
        chk("R5 dirty from inhibit", pdirty, 1);
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        inh = 1; shr = 1;
        do_op(OP_SERVICE);
        chk("R5 shared blocks dirty", pdirty, 0);
    endtask

    task automatic t_fill();
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        shr = 1;
        do_op(OP_SERVICE);
        do_op(OP_ADD, CMD_READ_EX, 2, 0);
        do_op(OP_ADD, CMD_SC, 3, 0);
        chk("R4 deferred excl", dex, 1);
        chk("R4 deferred upgrade", dup, 1);
        do_op(OP_FILL);
        chk("R11 shared fill no move", dcnt, 2);
        shr = 0;
        do_op(OP_FILL);
        chk("R11 spliced count", pcnt, 3);
        chk("R11 deferred empty", dcnt, 0);
        chk("R11 primary excl", pex, 1);
        chk("R11 deferred flags", dex | dup, 0);
        do_op(OP_POP);
        chk("R11 order kept", hord, 2);
        do_op(OP_POP);
        chk("R11 tail", hcmd, 4);
    endtask

    task automatic t_express();
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        do_op(OP_SERVICE);
        dpend = 1; expr = 1;
        do_op(OP_SNOOP, CMD_READ, 2, 0, 5);
        chk("R6 express unhandled", c_hand, 0);
        chk("R6 express no downgrade", pdown, 0);
        dpend = 0; expr = 0;
        do_reset();
        afwd = 1;
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        chk("R2 forward flag", fwd, 1);
        inh = 1; shr = 0;
        do_op(OP_SERVICE);
        do_op(OP_ADD, CMD_READ_EX, 2, 0);
        chk("R2 forward defers excl", dcnt, 1);
    endtask

    task automatic t_errors();
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        for (int i = 0; i < 3; i++) do_op(OP_ADD, CMD_READ, 2 + i, 0);
        chk("R13 full", pcnt, 4);
        chk("R13 no err yet", err, 0);
        do_op(OP_ADD, CMD_READ, 9, 0);
        chk("R13 overflow err", err, 1);
        chk("R13 dropped", pcnt, 4);
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        do_op(OP_ALLOC, CMD_READ, 7, 0);
        chk("R1 double alloc err", err, 1);
        chk("R1 order kept", eord, 1);
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        do_op(OP_DEALLOC);
        chk("R14 busy dealloc err", err, 1);
        chk("R14 still valid", valid, 1);
        do_reset();
        do_op(OP_ALLOC, CMD_READ, 1, 0);
        do_op(OP_SERVICE);
        do_op(OP_ADD, CMD_READ_EX, 2, 0);
        do_op(OP_PROMOTE, CMD_READ, 0, 0, 3);
        chk("R10 early promote err", err, 1);
        chk("R10 no swap", dcnt, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_before_service();
        t_service_route();
        t_dirty();
        t_fill();
        t_express();
        t_errors();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule